// File: doc/BRIEF.md
# Serial Codec Register Access Engine

This block serves control-register reads and writes that travel inside a framed, bit-serial stream between a host port and a small register file on the codec side. A rising edge on the frame-sync input starts a frame. The host side loads its pending command into a transmit shifter at that edge. The codec side decodes the address and the read/write flag as the bits arrive. It answers on the return line within the same frame. Both sides share one bit counter, and the stream runs at one bit per clock.

The two operations take effect at different points in the frame. A read samples the addressed register as soon as the read/write flag has been received, and the value is shifted back in the same frame. A write is held in a holding register and is committed only at the close of the first subframe. The frame that carries a write therefore returns the old contents, and the following frame returns the new value. The pending command is applied again in every frame until the host loads a new one. At the end of each complete frame, the host side latches the echoed address, flag and data, and raises a one-cycle valid pulse.

Top module: `sreg_engine`

## Requirements
- R1: After reset, all 16 registers hold zero, rsp_valid and the response fields are zero, both serial lines are low, and the pending command is a read of address 0.
- R2: A rising edge of fsync (sampled by the clock) starts a frame, and frame bit 0 is on the line in the next cycle. The pending command is copied into the transmit shifter at that edge. cmd_we only updates the pending command, so a command loaded in the middle of a frame takes effect at the next frame start.
- R3: The command stream on ser_tx is sent MSB first. Frame bits 36..39 carry the address, bit 40 carries the read/write flag (1 = write), and bits 41..56 carry the write data. All other bits of the frame are 0.
- R4: A read returns, on ser_rx in frame bits 41..56 (MSB first), the contents of the addressed register as they stand at the boundary between bit 40 and bit 41 of that same frame.
- R5: A write is committed to the addressed register at the clock edge that closes frame bit 64. The new value is visible from bit 65 onward, even if the frame is later cut short.
- R6: The frame that performs a write returns the register's previous contents. The next frame returns the written value.
- R7: The return stream echoes the address in bits 36..39, and its read/write bit (bit 40) is always 0. Bits 0..35 and bits 57 onward of the return stream are 0.
- R8: With no new cmd_we, every new frame repeats the same read or write.
- R9: A rising edge of fsync that arrives before the current frame ends restarts the bit counter at 0. It discards a write whose commit bit has not yet passed, and the cut-short frame produces no rsp_valid.
- R10: rsp_valid is a single-cycle pulse in the cycle after the last frame bit (FRAME_BITS-1). It carries the echoed address, the read/write bit and the data.
- R11: A write changes only the addressed register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one frame bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync; a rising edge starts a frame |
| cmd_we | input | 1 | Load a new pending command |
| cmd_addr | input | 4 | Register address of the command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | 16 | Data for a write command |
| ser_tx | output | 1 | Serial command stream, host to codec |
| ser_rx | output | 1 | Serial return stream, codec to host |
| rsp_valid | output | 1 | One-cycle pulse when a frame result is latched |
| rsp_addr | output | 4 | Echoed address |
| rsp_write | output | 1 | Echoed read/write bit (always 0) |
| rsp_data | output | 16 | Returned register value |

## Verification
Two events can fall on the same clock edge: a frame-sync restart and the write commit that is due at the close of bit 64. The question in each case is whether the commit survives. The bench cuts write frames short at about bit 50 and at about bit 80, and loads a read of the same register before each restart. Reading back the old value in the first case, and the new value in the second, shows on which side of the commit edge the restart landed. A second overlap arises when a command is loaded in the middle of a frame while a command is already loaded in the shifter. The bench checks that the current frame still echoes the old address and that the next frame uses the new one.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 16;
    localparam int NREGS      = 1 << ADDR_W;
    localparam int SUB0_BITS  = 64;
    localparam int ADDR_POS   = 36;
    localparam int RW_POS     = ADDR_POS + ADDR_W;
    localparam int DATA_POS   = RW_POS + 1;
    localparam int DATA_LAST  = DATA_POS + DATA_W - 1;
    localparam int COMMIT_BIT = SUB0_BITS;
    localparam int RSP_W      = ADDR_W + 1 + DATA_W;

    typedef int unsigned             uint_t;
    typedef logic [ADDR_W-1:0]       addr_t;
    typedef logic [DATA_W-1:0]       data_t;
    typedef logic [SUB0_BITS-1:0]    word_t;

    // Field order matches the serial order: address, flag, data.
    typedef struct packed {
        addr_t addr;
        logic  write;
        data_t data;
    } cmd_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_ADDR,
        PH_RW,
        PH_DATA,
        PH_COMMIT,
        PH_TAIL
    } phase_e;

    // Classify the frame bit currently on the line.
    function automatic phase_e phase_of(input logic active, input uint_t b);
        phase_e p;
        if (!active)                    p = PH_IDLE;
        else if (b < uint_t'(ADDR_POS)) p = PH_LEAD;
        else if (b < uint_t'(RW_POS))   p = PH_ADDR;
        else if (b == uint_t'(RW_POS))  p = PH_RW;
        else if (b <= uint_t'(DATA_LAST)) p = PH_DATA;
        else if (b == uint_t'(COMMIT_BIT)) p = PH_COMMIT;
        else                            p = PH_TAIL;
        return p;
    endfunction

    // Frame bit n of subframe 0 sits at word index SUB0_BITS-1-n.
    function automatic word_t pack_sub0(input cmd_t c);
        word_t w;
        w = '0;
        w[SUB0_BITS-1-ADDR_POS -: ADDR_W] = c.addr;
        w[SUB0_BITS-1-RW_POS]             = c.write;
        w[SUB0_BITS-1-DATA_POS -: DATA_W] = c.data;
        return w;
    endfunction

endpackage

// File: rtl/sreg_frame_timer.sv
module sreg_frame_timer #(
    parameter int FRAME_BITS = 128,
    parameter int CNT_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fsync,
    output logic             start,
    output logic             active,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

    logic fsync_q;

    assign start = fsync & ~fsync_q;
    assign last  = active && (cnt == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            fsync_q <= 1'b0;
            active  <= 1'b0;
            cnt     <= '0;
        end else begin
            fsync_q <= fsync;
            if (start) begin
                active <= 1'b1;
                cnt    <= '0;
            end else if (last) begin
                active <= 1'b0;
                cnt    <= '0;
            end else if (active) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sreg_regfile.sv
module sreg_regfile
    import sreg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  addr_t waddr,
    input  data_t wdata,
    input  addr_t raddr,
    output data_t rdata
);
    logic [NREGS-1:0][DATA_W-1:0] rows;

    for (genvar i = 0; i < NREGS; i++) begin : g_row
        data_t q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (we && (waddr == addr_t'(i)))
                q <= wdata;
        end
        assign rows[i] = q;
    end

    assign rdata = rows[raddr];
endmodule

// File: rtl/sreg_host_port.sv
module sreg_host_port
    import sreg_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             active,
    input  logic [CNT_W-1:0] cnt,
    input  logic             last,
    input  logic             cmd_we,
    input  cmd_t             cmd_in,
    input  logic             ser_rx,
    output logic             ser_tx,
    output logic             rsp_valid,
    output cmd_t             rsp
);
    cmd_t             pend_q;
    word_t            tx_sh;
    logic [RSP_W-1:0] rx_sh;
    phase_e           ph;

    assign ph     = phase_of(active, uint_t'(cnt));
    assign ser_tx = active & tx_sh[SUB0_BITS-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            rsp_valid <= 1'b0;
            rsp       <= '0;
        end else begin
            if (cmd_we)
                pend_q <= cmd_in;

            if (start)
                tx_sh <= pack_sub0(pend_q);
            else if (active)
                tx_sh <= {tx_sh[SUB0_BITS-2:0], 1'b0};

            if (ph inside {PH_ADDR, PH_RW, PH_DATA})
                rx_sh <= {rx_sh[RSP_W-2:0], ser_rx};

            rsp_valid <= 1'b0;
            if (last && !start) begin
                rsp       <= cmd_t'(rx_sh);
                rsp_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sreg_codec_engine.sv
module sreg_codec_engine
    import sreg_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             active,
    input  logic [CNT_W-1:0] cnt,
    input  logic             sdi,
    input  data_t            rd_data,
    output logic             sdo,
    output addr_t            rd_addr,
    output logic             wr_en,
    output addr_t            wr_addr,
    output data_t            wr_data
);
    addr_t  addr_q;
    logic   rw_q;
    data_t  hold_q;
    data_t  ret_sh;
    phase_e ph;

    assign ph = phase_of(active, uint_t'(cnt));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            rw_q   <= 1'b0;
            hold_q <= '0;
            ret_sh <= '0;
        end else if (start) begin
            rw_q <= 1'b0;            // drops a commit not yet reached
        end else begin
            case (ph)
                PH_ADDR: addr_q <= {addr_q[ADDR_W-2:0], sdi};
                PH_RW: begin
                    rw_q   <= sdi;
                    ret_sh <= rd_data;   // snapshot before any commit
                end
                PH_DATA: begin
                    hold_q <= {hold_q[DATA_W-2:0], sdi};
                    ret_sh <= {ret_sh[DATA_W-2:0], 1'b0};
                end
                default: ;
            endcase
        end
    end

    assign rd_addr = addr_q;
    assign wr_en   = (ph == PH_COMMIT) && rw_q;
    assign wr_addr = addr_q;
    assign wr_data = hold_q;

    always_comb begin
        case (ph)
            PH_ADDR: sdo = sdi;
            PH_DATA: sdo = ret_sh[DATA_W-1];
            default: sdo = 1'b0;
        endcase
    end
endmodule

// File: rtl/sreg_engine.sv
module sreg_engine
    import sreg_pkg::*;
#(
    parameter int FRAME_BITS = 128,
    parameter int CNT_W      = $clog2(FRAME_BITS)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fsync,
    input  logic        cmd_we,
    input  logic [3:0]  cmd_addr,
    input  logic        cmd_write,
    input  logic [15:0] cmd_wdata,
    output logic        ser_tx,
    output logic        ser_rx,
    output logic        rsp_valid,
    output logic [3:0]  rsp_addr,
    output logic        rsp_write,
    output logic [15:0] rsp_data
);
    logic             frm_start;
    logic             frm_active;
    logic [CNT_W-1:0] frm_cnt;
    logic             frm_last;
    logic             reg_we;
    addr_t            reg_waddr;
    data_t            reg_wdata;
    addr_t            reg_raddr;
    data_t            reg_rdata;
    cmd_t             cmd_in;
    cmd_t             rsp;

    assign cmd_in = '{addr: cmd_addr, write: cmd_write, data: cmd_wdata};

    sreg_frame_timer #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .fsync(fsync),
        .start(frm_start), .active(frm_active), .cnt(frm_cnt), .last(frm_last)
    );

    sreg_host_port #(.CNT_W(CNT_W)) u_host (
        .clk(clk), .rst(rst), .start(frm_start), .active(frm_active),
        .cnt(frm_cnt), .last(frm_last), .cmd_we(cmd_we), .cmd_in(cmd_in),
        .ser_rx(ser_rx), .ser_tx(ser_tx), .rsp_valid(rsp_valid), .rsp(rsp)
    );

    sreg_codec_engine #(.CNT_W(CNT_W)) u_codec (
        .clk(clk), .rst(rst), .start(frm_start), .active(frm_active),
        .cnt(frm_cnt), .sdi(ser_tx), .rd_data(reg_rdata), .sdo(ser_rx),
        .rd_addr(reg_raddr), .wr_en(reg_we), .wr_addr(reg_waddr),
        .wr_data(reg_wdata)
    );

    sreg_regfile u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .waddr(reg_waddr),
        .wdata(reg_wdata), .raddr(reg_raddr), .rdata(reg_rdata)
    );

    assign rsp_addr  = rsp.addr;
    assign rsp_write = rsp.write;
    assign rsp_data  = rsp.data;
endmodule

// File: rtl/sreg_engine_chk.sv
module sreg_engine_chk
    import sreg_pkg::*;
#(
    parameter int FRAME_BITS = 128,
    parameter int CNT_W      = $clog2(FRAME_BITS)
) (
    input logic             clk,
    input logic             rst,
    input logic             fsync,
    input logic             frm_active,
    input logic [CNT_W-1:0] frm_cnt,
    input logic             reg_we,
    input logic             ser_tx,
    input logic             ser_rx,
    input logic             rsp_valid,
    input logic             rsp_write
);
    p_frame_start_r2: assert property (@(posedge clk) disable iff (rst)
        (fsync && !$past(fsync)) |=> (frm_active && frm_cnt == '0));

    p_lead_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (frm_active && frm_cnt < CNT_W'(ADDR_POS)) |-> (!ser_tx && !ser_rx));

    p_tail_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (frm_active && frm_cnt > CNT_W'(DATA_LAST)) |-> !ser_tx);

    p_commit_slot_r5: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> (frm_active && frm_cnt == CNT_W'(COMMIT_BIT)));

    p_rw_echo_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (frm_active && frm_cnt == CNT_W'(RW_POS)) |-> !ser_rx);

    p_rsp_rw_zero_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !rsp_write);

    p_rsp_after_last_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(frm_active && frm_cnt == CNT_W'(FRAME_BITS - 1)));

    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

bind sreg_engine sreg_engine_chk #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .fsync(fsync), .frm_active(frm_active),
    .frm_cnt(frm_cnt), .reg_we(reg_we), .ser_tx(ser_tx), .ser_rx(ser_rx),
    .rsp_valid(rsp_valid), .rsp_write(rsp_write)
);

// File: tb/sreg_engine_tb.sv
`timescale 1ns/1ps
module sreg_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fsync = 1'b0;
    logic        cmd_we = 1'b0;
    logic [3:0]  cmd_addr = '0;
    logic        cmd_write = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic        ser_tx, ser_rx, rsp_valid, rsp_write;
    logic [3:0]  rsp_addr;
    logic [15:0] rsp_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sreg_engine u_dut (
        .clk(clk), .rst(rst), .fsync(fsync), .cmd_we(cmd_we),
        .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_wdata(cmd_wdata),
        .ser_tx(ser_tx), .ser_rx(ser_rx), .rsp_valid(rsp_valid),
        .rsp_addr(rsp_addr), .rsp_write(rsp_write), .rsp_data(rsp_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_cmd(input logic [3:0] a, input logic w, input logic [15:0] d);
        @(negedge clk);
        cmd_we = 1'b1; cmd_addr = a; cmd_write = w; cmd_wdata = d;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic wait_rsp(output logic seen);
        int guard = 0;
        while (!rsp_valid && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        seen = rsp_valid;
    endtask

    // One full frame: records both lines for subframe 0, then checks the response.
    task automatic run_frame(input logic [3:0] a, input logic w, input logic [15:0] wd,
                             input logic [15:0] exp_d, input string tag);
        logic [63:0] txb, rxb, exp_tx, exp_rx;
        logic seen;
        @(negedge clk) fsync = 1'b1;
        for (int n = 0; n < 64; n++) begin
            @(negedge clk);
            if (n == 0) fsync = 1'b0;
            txb[63-n] = ser_tx;
            rxb[63-n] = ser_rx;
        end
        exp_tx = '0; exp_tx[27:24] = a; exp_tx[23] = w; exp_tx[22:7] = wd;
        exp_rx = '0; exp_rx[27:24] = a; exp_rx[22:7] = exp_d;
        chk({tag, " R3 tx stream"}, txb, exp_tx);
        chk({tag, " R4 R7 return stream"}, rxb, exp_rx);
        wait_rsp(seen);
        chk({tag, " R10 rsp_valid"}, 64'(seen), 64'd1);
        chk({tag, " R10 rsp fields"}, {43'd0, rsp_addr, rsp_write, rsp_data},
            {43'd0, a, 1'b0, exp_d});
        @(negedge clk);
        chk({tag, " R10 single pulse"}, 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_reset;
        chk("R1 outputs after reset",
            {40'd0, rsp_valid, rsp_addr, rsp_write, rsp_data, ser_tx, ser_rx}, 64'd0);
        run_frame(4'd0, 1'b0, 16'h0, 16'h0, "R1 default read addr 0");
    endtask

    task automatic t_read_fresh;
        set_cmd(4'd5, 1'b0, 16'hFFFF);
        run_frame(4'd5, 1'b0, 16'hFFFF, 16'h0, "R4 read reset register");
    endtask

    task automatic t_write_echo;
        set_cmd(4'd3, 1'b1, 16'hA5C3);
        run_frame(4'd3, 1'b1, 16'hA5C3, 16'h0000, "R6 write frame returns old");
        run_frame(4'd3, 1'b1, 16'hA5C3, 16'hA5C3, "R6 R8 repeated write returns new");
        set_cmd(4'd3, 1'b1, 16'h1234);
        run_frame(4'd3, 1'b1, 16'h1234, 16'hA5C3, "R6 overwrite returns previous");
        run_frame(4'd3, 1'b1, 16'h1234, 16'h1234, "R6 overwrite next frame");
    endtask

    task automatic t_read_repeat;
        set_cmd(4'd3, 1'b0, 16'h0);
        run_frame(4'd3, 1'b0, 16'h0, 16'h1234, "R4 read back");
        run_frame(4'd3, 1'b0, 16'h0, 16'h1234, "R8 repeated read");
    endtask

    task automatic t_isolation;
        set_cmd(4'd15, 1'b1, 16'hFFFF);
        run_frame(4'd15, 1'b1, 16'hFFFF, 16'h0, "R11 write top address");
        set_cmd(4'd14, 1'b0, 16'h0);
        run_frame(4'd14, 1'b0, 16'h0, 16'h0, "R11 neighbour below untouched");
        set_cmd(4'd2, 1'b0, 16'h0);
        run_frame(4'd2, 1'b0, 16'h0, 16'h0, "R11 neighbour of reg 3 untouched");
        set_cmd(4'd15, 1'b0, 16'h0);
        run_frame(4'd15, 1'b0, 16'h0, 16'hFFFF, "R11 top address holds value");
    endtask

    // Restart near bit 50: the write has not reached its commit bit.
    task automatic t_abort_early;
        int stray = 0;
        set_cmd(4'd7, 1'b1, 16'hBEEF);
        @(negedge clk) fsync = 1'b1;
        @(negedge clk) fsync = 1'b0;
        for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            if (rsp_valid) stray++;
        end
        set_cmd(4'd7, 1'b0, 16'h0);
        run_frame(4'd7, 1'b0, 16'h0, 16'h0, "R9 early restart drops write");
        chk("R9 no response from cut frame", 64'(stray), 64'd0);
    endtask

    // Restart near bit 80: the commit at bit 64 already happened.
    task automatic t_abort_late;
        set_cmd(4'd8, 1'b1, 16'h0F0F);
        @(negedge clk) fsync = 1'b1;
        @(negedge clk) fsync = 1'b0;
        repeat (78) @(negedge clk);
        set_cmd(4'd8, 1'b0, 16'h0);
        run_frame(4'd8, 1'b0, 16'h0, 16'h0F0F, "R5 commit kept after bit 64");
    endtask

    // Command loaded mid-frame does not disturb the frame in flight.
    task automatic t_midframe_cmd;
        logic seen;
        set_cmd(4'd3, 1'b0, 16'h0);
        @(negedge clk) fsync = 1'b1;
        @(negedge clk) fsync = 1'b0;
        repeat (10) @(negedge clk);
        set_cmd(4'd4, 1'b0, 16'h0);
        wait_rsp(seen);
        chk("R2 frame in flight keeps old command",
            {43'd0, seen, rsp_addr, rsp_data}, {43'd0, 1'b1, 4'd3, 16'h1234});
        @(negedge clk);
        run_frame(4'd4, 1'b0, 16'h0, 16'h0, "R2 new command on next frame");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_fresh();
        t_write_echo();
        t_read_repeat();
        t_isolation();
        t_abort_early();
        t_abort_late();
        t_midframe_cmd();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule